// File: doc/BRIEF.md
# Single-Digit Decimal Adder

This block adds two decimal digits, each held as a 4-bit binary-coded value from 0 to 9, together with a carry-in bit. It returns one corrected decimal sum digit and a decimal carry-out. Internally it works in two binary stages. The first stage forms a plain binary sum. A small control unit then checks whether that sum has left the decimal range. If it has, the second stage adds six, which folds the result back into a valid digit and produces the carry.

The block is purely combinational and has no clock. To build a multi-digit decimal adder, instantiate one copy per digit and connect each carry-out to the next copy's carry-in; that chaining is done at the parent level. The result is unspecified when an operand is 10 to 15.

Top module: `bcdDigitAdder`

## Requirements
- R1: For valid operands, `sumDigit` equals (`digitA` + `digitB` + `carryIn`) modulo 10, coded as a 4-bit binary value.
- R2: For valid operands, `carryOut` is 1 exactly when `digitA` + `digitB` + `carryIn` is 10 or more.
- R3: When the total is 9 or less, no correction is applied: `sumDigit` equals the total and `carryOut` is 0.
- R4: When the total is 10 to 15 (no binary carry from the first stage), `sumDigit` equals the total minus 10 and `carryOut` is 1.
- R5: When the total is 16 to 19 (the first stage carries out), `sumDigit` equals the total minus 10 and `carryOut` is 1.
- R6: `carryIn` is part of the first-stage sum. 0 + 0 + 1 gives sum 1 with carry 0, and 9 + 9 + 1 gives sum 9 (1001) with carry 1.
- R7: The following input pairs, each with carry-in 0, give these results: 0010 + 0110 gives sum 1000 with carry 0; 1000 + 1001 gives sum 0111 with carry 1; 0110 + 0101 gives sum 0001 with carry 1.
- R8: For valid operands, `sumDigit` never exceeds 9.
- R9: The outputs depend only on the current inputs and are valid in the same cycle in which the inputs are applied, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digitA | input | 4 | First decimal operand digit (0 to 9) |
| digitB | input | 4 | Second decimal operand digit (0 to 9) |
| carryIn | input | 1 | Decimal carry from the less significant digit |
| sumDigit | output | 4 | Corrected decimal sum digit |
| carryOut | output | 1 | Decimal carry to the more significant digit |

## Verification
The block holds no state, so every result is due zero cycles after its inputs change. The bench drives each input set on a falling clock edge and samples both outputs one nanosecond later, inside the same cycle and well before the next rising edge. This fixed spacing gives the combinational path time to settle without relying on any register. Every valid pair of digits is applied with both carry-in values, and each result is compared with a total computed in decimal arithmetic.

// File: rtl/bcdAddPkg.sv
package bcdAddPkg;
  localparam int DigitW = 4;
  localparam logic [DigitW-1:0] DecFix = DigitW'(6);
  localparam int DecMax = 9;

  typedef struct packed {
    logic addSix;
  } fixStrobe_t;
endpackage

// File: rtl/bcdRipple.sv
module bcdRipple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cIn,
  output logic [W-1:0] s,
  output logic         cOut
);
  logic [W:0] chain;

  assign chain[0] = cIn;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]       = x[i] ^ y[i] ^ chain[i];
    assign chain[i+1] = (x[i] & y[i]) | (x[i] & chain[i]) | (y[i] & chain[i]);
  end

  assign cOut = chain[W];
endmodule

// File: rtl/bcdSumPath.sv
module bcdSumPath
  import bcdAddPkg::*;
(
  input  logic [DigitW-1:0] opA,
  input  logic [DigitW-1:0] opB,
  input  logic              cIn,
  input  fixStrobe_t        strobe,
  output logic [DigitW-1:0] rawSum,
  output logic              rawCarry,
  output logic [DigitW-1:0] fixedSum,
  output logic              fixCarry
);
  logic [DigitW-1:0] addend;

  // first stage: plain binary add including the incoming carry
  bcdRipple #(.W(DigitW)) uStage1 (
    .x(opA), .y(opB), .cIn(cIn), .s(rawSum), .cOut(rawCarry)
  );

  // two-way pick between zero and the decimal fix value
  assign addend = strobe.addSix ? DecFix : '0;

  // second stage: apply the correction
  bcdRipple #(.W(DigitW)) uStage2 (
    .x(rawSum), .y(addend), .cIn(1'b0), .s(fixedSum), .cOut(fixCarry)
  );
endmodule

// File: rtl/bcdFixCtrl.sv
module bcdFixCtrl
  import bcdAddPkg::*;
(
  input  logic [DigitW-1:0] rawSum,
  input  logic              rawCarry,
  input  logic              fixCarry,
  output fixStrobe_t        strobe,
  output logic              decCarry
);
  localparam int TopBit = DigitW - 1;

  // out of decimal range: a binary carry, or an 8-weight bit with 4 or 2 set
  always_comb begin
    strobe        = '0;
    strobe.addSix = rawCarry | (rawSum[TopBit] & (rawSum[TopBit-1] | rawSum[TopBit-2]));
  end

  assign decCarry = rawCarry | fixCarry;
endmodule

// File: rtl/bcdDigitAdder.sv
module bcdDigitAdder
  import bcdAddPkg::*;
(
  input  logic [3:0] digitA,
  input  logic [3:0] digitB,
  input  logic       carryIn,
  output logic [3:0] sumDigit,
  output logic       carryOut
);
  fixStrobe_t        strobe;
  logic [DigitW-1:0] rawSum;
  logic              rawCarry;
  logic              fixCarry;

  bcdSumPath uPath (
    .opA(digitA), .opB(digitB), .cIn(carryIn), .strobe(strobe),
    .rawSum(rawSum), .rawCarry(rawCarry), .fixedSum(sumDigit), .fixCarry(fixCarry)
  );

  bcdFixCtrl uCtrl (
    .rawSum(rawSum), .rawCarry(rawCarry), .fixCarry(fixCarry),
    .strobe(strobe), .decCarry(carryOut)
  );
endmodule

// File: rtl/bcdDigitAdderChk.sv
module bcdDigitAdderChk (
  input logic [3:0] digitA,
  input logic [3:0] digitB,
  input logic       carryIn,
  input logic [3:0] sumDigit,
  input logic       carryOut
);
  logic [4:0] total;
  logic       validIn;

  assign total   = 5'(digitA) + 5'(digitB) + 5'(carryIn);
  assign validIn = (digitA <= 4'd9) && (digitB <= 4'd9);

  always_comb begin
    if (validIn) begin
      assert_sum_digit_R1: assert (5'(sumDigit) == total % 5'd10)
        else $error("R1 sum digit mismatch");
      assert_carry_R2: assert (carryOut == (total >= 5'd10))
        else $error("R2 carry mismatch");
      assert_bcd_range_R8: assert (sumDigit <= 4'd9)
        else $error("R8 sum out of range");
      if (total <= 5'd9) begin
        assert_no_fix_R3: assert (sumDigit == total[3:0] && !carryOut)
          else $error("R3 unexpected correction");
      end
      if (total >= 5'd16) begin
        assert_high_fix_R5: assert (carryOut && 5'(sumDigit) == total - 5'd10)
          else $error("R5 high range correction");
      end
    end
  end
endmodule

bind bcdDigitAdder bcdDigitAdderChk uChk (
  .digitA(digitA), .digitB(digitB), .carryIn(carryIn),
  .sumDigit(sumDigit), .carryOut(carryOut)
);

// File: tb/tb_bcdDigitAdder.sv
module tb_bcdDigitAdder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] digitA = '0;
  logic [3:0] digitB = '0;
  logic       carryIn = 1'b0;
  logic [3:0] sumDigit;
  logic       carryOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bcdDigitAdder dut (
    .digitA(digitA), .digitB(digitB), .carryIn(carryIn),
    .sumDigit(sumDigit), .carryOut(carryOut)
  );

  task automatic applyAndCheck(input int a, input int b, input int c,
                               input int expSum, input int expCarry, input string req);
    @(negedge clk);
    digitA  = 4'(a);
    digitB  = 4'(b);
    carryIn = 1'(c);
    #1;
    checks++;
    if (int'(sumDigit) != expSum || int'(carryOut) != expCarry) begin
      failures++;
      $display("FAIL %s: %0d+%0d+%0d actual sum=%0d carry=%0d expected sum=%0d carry=%0d",
               req, a, b, c, sumDigit, carryOut, expSum, expCarry);
    end
  endtask

  task automatic checkIdle();
    applyAndCheck(0, 0, 0, 0, 0, "R3 idle");
  endtask

  task automatic testExamples();
    applyAndCheck(2, 6, 0, 8, 0, "R7");
    applyAndCheck(8, 9, 0, 7, 1, "R7");
    applyAndCheck(6, 5, 0, 1, 1, "R7");
  endtask

  task automatic testNoFix();
    applyAndCheck(4, 5, 0, 9, 0, "R3");
    applyAndCheck(3, 5, 1, 9, 0, "R3");
    applyAndCheck(1, 7, 0, 8, 0, "R3");
  endtask

  task automatic testMidFix();
    applyAndCheck(5, 5, 0, 0, 1, "R4");
    applyAndCheck(9, 4, 1, 4, 1, "R4");
    applyAndCheck(7, 8, 0, 5, 1, "R4");
  endtask

  task automatic testHighFix();
    applyAndCheck(8, 8, 0, 6, 1, "R5");
    applyAndCheck(9, 9, 0, 8, 1, "R5");
    applyAndCheck(9, 7, 1, 7, 1, "R5");
  endtask

  task automatic testCarryIn();
    applyAndCheck(0, 0, 1, 1, 0, "R6");
    applyAndCheck(9, 9, 1, 9, 1, "R6");
    applyAndCheck(4, 5, 1, 0, 1, "R6");
  endtask

  // full sweep: R1, R2, R8, R9 (sampled in the same cycle as the stimulus)
  task automatic testSweep();
    for (int a = 0; a <= 9; a++) begin
      for (int b = 0; b <= 9; b++) begin
        for (int c = 0; c <= 1; c++) begin
          int tot = a + b + c;
          applyAndCheck(a, b, c, tot % 10, (tot >= 10) ? 1 : 0, "R1/R2 sweep R9");
          checks++;
          if (sumDigit > 4'd9) begin
            failures++;
            $display("FAIL R8: actual sum=%0d expected at most 9", sumDigit);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    checkIdle();
    testExamples();
    testNoFix();
    testMidFix();
    testHighFix();
    testCarryIn();
    testSweep();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule